// File: doc/BRIEF.md
# Memory Recalibration Mailbox Sequencer

This block acts as an AXI-Lite master that asks a memory controller, through its mailbox registers, to recalibrate one of two channels, and then collects the outcome. A host pulses `start_i` with a channel choice and two register addresses. The sequencer writes one packed command word to the command-request register. It polls the response-status register until the response-ready flag appears and clears that flag with a read-modify-write. It then polls the same register for the calibration verdict and clears the ready flag a second time before reporting.

The verdict is taken from the three low status bits. One bit means every instance calibrated, one means at least one instance failed, and one means calibration is still running. If the busy indication persists beyond a cycle-count limit, polling gives up and a timeout is reported. A bus error on any transfer ends the sequence early.

Top module: `recal_mbox_seq`

## Requirements
- R1: The first bus transfer after an accepted start is a write of the command word to `req_addr_i` with all byte strobes set. The word holds target type in bits [31:29], instance 0 in [28:24], command kind 0x05 in [23:16] and opcode 0x000A in [15:0]. Target type is 1 when `chan_sel_i`=0 (word 0x2005_000A) and 3 when `chan_sel_i`=1 (word 0x6005_000A).
- R2: After the command write, the sequencer reads `stat_addr_i` repeatedly until a read returns bit 0 set.
- R3: Each ready-clear is a read of `stat_addr_i` followed by a write to `stat_addr_i` of the value read ANDed with 0xFFFF_FFFE. One clear follows the ready poll and one follows the verdict poll.
- R4: The verdict poll stops when a read shows bit 1 or bit 0 set. Bit 1 gives `fail_o`=1. Bit 0 with bit 1 clear gives `pass_o`=1. When both are set, fail wins.
- R5: While verdict reads show bit 2 set with bits 1 and 0 clear, a counter advances from the start of the verdict phase. Once it reaches `TIMEOUT_CYCLES`, the next such read stops polling. The second clear is still performed, then `timeout_o`=1 with `pass_o`=`fail_o`=0.
- R6: Address and data valid signals are held, with stable address and data, until the matching ready. A new transfer starts only after the previous response handshake.
- R7: A response other than OKAY (code 0) on any transfer ends the sequence at once with `done_o`=1 and `error_o`=1, and no further transfer is issued.
- R8: `start_i` is ignored while a sequence runs. An accepted start drops `done_o` and all result flags in the following cycle.
- R9: After reset, `done_o`, all result flags and all valid outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| chan_sel_i | input | 1 | Channel select: 0 first channel, 1 second channel |
| req_addr_i | input | ADDR_W | Command-request register address |
| stat_addr_i | input | ADDR_W | Response-status register address |
| done_o | output | 1 | Sequence finished, held until next start |
| pass_o | output | 1 | Calibration passed |
| fail_o | output | 1 | Calibration failed |
| timeout_o | output | 1 | Busy timeout expired |
| error_o | output | 1 | Bus response error |
| m_awvalid_o | output | 1 | Write address valid |
| m_awready_i | input | 1 | Write address ready |
| m_awaddr_o | output | ADDR_W | Write address |
| m_wvalid_o | output | 1 | Write data valid |
| m_wready_i | input | 1 | Write data ready |
| m_wdata_o | output | 32 | Write data |
| m_wstrb_o | output | 4 | Write byte strobes |
| m_bvalid_i | input | 1 | Write response valid |
| m_bready_o | output | 1 | Write response ready |
| m_bresp_i | input | 2 | Write response code |
| m_arvalid_o | output | 1 | Read address valid |
| m_arready_i | input | 1 | Read address ready |
| m_araddr_o | output | ADDR_W | Read address |
| m_rvalid_i | input | 1 | Read data valid |
| m_rready_o | output | 1 | Read data ready |
| m_rdata_i | input | 32 | Read data |
| m_rresp_i | input | 2 | Read response code |

## Verification
The pass and fail decodes can both fire on one verdict read when the status word carries bits 0 and 1 together. The bench provokes this with slave vectors whose final status is 0b011 and 0b111. It judges the result by `fail_o`=1 with `pass_o`=0 at completion, together with the usual clear-write value. Busy-plus-pass (0b101) is also driven, to confirm that the busy bit does not mask a verdict.

// File: rtl/recal_pkg.sv
package recal_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_REQ,
      S_POLL_RDY,
      S_RD_CLR1,
      S_WR_CLR1,
      S_POLL_CAL,
      S_RD_CLR2,
      S_WR_CLR2
   } seq_st_e;

   typedef enum logic [2:0] {
      E_IDLE,
      E_WADDR,
      E_WRESP,
      E_RADDR,
      E_RDATA
   } eng_st_e;

   localparam logic [1:0] RESP_OKAY = 2'b00;

   localparam int BIT_RDY  = 0;
   localparam int BIT_FAIL = 1;
   localparam int BIT_BUSY = 2;

   function automatic logic [31:0] pack_cmd(input logic [2:0]  tgt,
                                            input logic [4:0]  inst,
                                            input logic [7:0]  kind,
                                            input logic [15:0] op);
      return {tgt, inst, kind, op};
   endfunction

endpackage

// File: rtl/recal_cmd_pack.sv
module recal_cmd_pack
   import recal_pkg::*;
#(
   parameter logic [2:0]  TGT_CH0  = 3'h1,
   parameter logic [2:0]  TGT_CH1  = 3'h3,
   parameter logic [4:0]  INST_ID  = 5'h00,
   parameter logic [7:0]  CMD_KIND = 8'h05,
   parameter logic [15:0] CMD_OP   = 16'h000A,
   parameter bit          REG_OUT  = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load_i,
   input  logic        chan_i,
   output logic [31:0] cmd_o
);

   logic [2:0]  tgt_sel;
   logic [31:0] cmd_next;

   assign tgt_sel  = chan_i ? TGT_CH1 : TGT_CH0;
   assign cmd_next = pack_cmd(tgt_sel, INST_ID, CMD_KIND, CMD_OP);

   generate
      if (REG_OUT) begin : g_reg
         logic [31:0] cmd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cmd_q <= '0;
            else if (load_i) cmd_q <= cmd_next;
         end
         assign cmd_o = cmd_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n ^ load_i;
         assign cmd_o = cmd_next;
      end
   endgenerate

endmodule

// File: rtl/recal_busy_timer.sv
module recal_busy_timer #(
   parameter int LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic run_i,
   input  logic sample_i,
   input  logic busy_i,
   output logic expired_o
);

   localparam int CW = $clog2(LIMIT + 1);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("recal_busy_timer: LIMIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
      end else if (clr_i) begin
         busy_q <= 1'b0;
      end else if (sample_i) begin
         busy_q <= busy_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i || (sample_i && !busy_i)) begin
         cnt_q <= '0;
      end else if (run_i && busy_q && (cnt_q != CW'(LIMIT))) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expired_o = (cnt_q == CW'(LIMIT));

   // R5
   tmr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !expired_o);

   // R5
   tmr_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(LIMIT));

endmodule

// File: rtl/recal_axil_port.sv
module recal_axil_port
   import recal_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic              is_wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              idle_o,
   output logic              fin_o,
   output logic              err_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              m_awvalid_o,
   input  logic              m_awready_i,
   output logic [ADDR_W-1:0] m_awaddr_o,
   output logic              m_wvalid_o,
   input  logic              m_wready_i,
   output logic [DATA_W-1:0] m_wdata_o,
   output logic [DATA_W/8-1:0] m_wstrb_o,
   input  logic              m_bvalid_i,
   output logic              m_bready_o,
   input  logic [1:0]        m_bresp_i,
   output logic              m_arvalid_o,
   input  logic              m_arready_i,
   output logic [ADDR_W-1:0] m_araddr_o,
   input  logic              m_rvalid_i,
   output logic              m_rready_o,
   input  logic [DATA_W-1:0] m_rdata_i,
   input  logic [1:0]        m_rresp_i
);

   localparam int STRB_W = DATA_W / 8;

   generate
      if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_bad_data
         $error("recal_axil_port: DATA_W must be a multiple of 8");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("recal_axil_port: ADDR_W must be positive");
      end
   endgenerate

   eng_st_e           st_q;
   logic              awv_q, wv_q, arv_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              aw_ok, w_ok;

   assign aw_ok = !awv_q || m_awready_i;
   assign w_ok  = !wv_q  || m_wready_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= E_IDLE;
         awv_q   <= 1'b0;
         wv_q    <= 1'b0;
         arv_q   <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         unique case (st_q)
            E_IDLE: begin
               if (go_i) begin
                  addr_q  <= addr_i;
                  wdata_q <= wdata_i;
                  if (is_wr_i) begin
                     awv_q <= 1'b1;
                     wv_q  <= 1'b1;
                     st_q  <= E_WADDR;
                  end else begin
                     arv_q <= 1'b1;
                     st_q  <= E_RADDR;
                  end
               end
            end
            E_WADDR: begin
               if (awv_q && m_awready_i) awv_q <= 1'b0;
               if (wv_q && m_wready_i)   wv_q  <= 1'b0;
               if (aw_ok && w_ok)        st_q  <= E_WRESP;
            end
            E_WRESP: begin
               if (m_bvalid_i) st_q <= E_IDLE;
            end
            E_RADDR: begin
               if (m_arready_i) begin
                  arv_q <= 1'b0;
                  st_q  <= E_RDATA;
               end
            end
            E_RDATA: begin
               if (m_rvalid_i) st_q <= E_IDLE;
            end
            default: st_q <= E_IDLE;
         endcase
      end
   end

   assign idle_o      = (st_q == E_IDLE);
   assign m_awvalid_o = awv_q;
   assign m_wvalid_o  = wv_q;
   assign m_arvalid_o = arv_q;
   assign m_awaddr_o  = addr_q;
   assign m_araddr_o  = addr_q;
   assign m_wdata_o   = wdata_q;
   assign m_wstrb_o   = {STRB_W{1'b1}};
   assign m_bready_o  = (st_q == E_WRESP);
   assign m_rready_o  = (st_q == E_RDATA);

   always_comb begin
      fin_o   = 1'b0;
      err_o   = 1'b0;
      rdata_o = m_rdata_i;
      if (st_q == E_WRESP && m_bvalid_i) begin
         fin_o = 1'b1;
         err_o = (m_bresp_i != RESP_OKAY);
      end else if (st_q == E_RDATA && m_rvalid_i) begin
         fin_o = 1'b1;
         err_o = (m_rresp_i != RESP_OKAY);
      end
   end

   // R6
   aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_awvalid_o && !m_awready_i) |=> (m_awvalid_o && $stable(m_awaddr_o)));

   // R6
   w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_wvalid_o && !m_wready_i) |=> (m_wvalid_o && $stable(m_wdata_o)));

   // R6
   ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_arvalid_o && !m_arready_i) |=> (m_arvalid_o && $stable(m_araddr_o)));

   // R6
   one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(m_arvalid_o && (m_awvalid_o || m_wvalid_o)));

endmodule

// File: rtl/recal_mbox_seq.sv
module recal_mbox_seq
   import recal_pkg::*;
#(
   parameter int          ADDR_W         = 32,
   parameter int          TIMEOUT_CYCLES = 2000000000,
   parameter logic [2:0]  TGT_CH0        = 3'h1,
   parameter logic [2:0]  TGT_CH1        = 3'h3,
   parameter logic [4:0]  INST_ID        = 5'h00,
   parameter logic [7:0]  CMD_KIND       = 8'h05,
   parameter logic [15:0] CMD_OP         = 16'h000A,
   parameter bit          REG_CMD        = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              chan_sel_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [ADDR_W-1:0] stat_addr_i,
   output logic              done_o,
   output logic              pass_o,
   output logic              fail_o,
   output logic              timeout_o,
   output logic              error_o,
   output logic              m_awvalid_o,
   input  logic              m_awready_i,
   output logic [ADDR_W-1:0] m_awaddr_o,
   output logic              m_wvalid_o,
   input  logic              m_wready_i,
   output logic [31:0]       m_wdata_o,
   output logic [3:0]        m_wstrb_o,
   input  logic              m_bvalid_i,
   output logic              m_bready_o,
   input  logic [1:0]        m_bresp_i,
   output logic              m_arvalid_o,
   input  logic              m_arready_i,
   output logic [ADDR_W-1:0] m_araddr_o,
   input  logic              m_rvalid_i,
   output logic              m_rready_o,
   input  logic [31:0]       m_rdata_i,
   input  logic [1:0]        m_rresp_i
);

   localparam int          DATA_W   = 32;
   localparam logic [31:0] CLR_MASK = ~(32'd1 << BIT_RDY);

   generate
      if (TIMEOUT_CYCLES < 1) begin : g_bad_tmo
         $error("recal_mbox_seq: TIMEOUT_CYCLES must be at least 1");
      end
   endgenerate

   seq_st_e           st_q;
   logic              wait_q;
   logic              chan_q;
   logic [ADDR_W-1:0] req_addr_q, stat_addr_q;
   logic [31:0]       hold_q;
   logic              v_pass_q, v_fail_q, v_tout_q;
   logic              done_q, pass_q, fail_q, tout_q, err_q;

   logic              accept;
   logic              go, is_wr, eng_idle, fin, eng_err;
   logic [ADDR_W-1:0] go_addr;
   logic [31:0]       go_wdata, rd, cmd_word;
   logic              tmr_clr, tmr_run, tmr_sample, tmr_busy, tmr_exp;
   logic              rd_rdy, rd_fail, rd_busy;

   assign accept = start_i && (st_q == S_IDLE);

   recal_cmd_pack #(
      .TGT_CH0 (TGT_CH0),
      .TGT_CH1 (TGT_CH1),
      .INST_ID (INST_ID),
      .CMD_KIND(CMD_KIND),
      .CMD_OP  (CMD_OP),
      .REG_OUT (REG_CMD)
   ) u_pack (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(accept),
      .chan_i(REG_CMD ? chan_sel_i : chan_q),
      .cmd_o (cmd_word)
   );

   assign go       = (st_q != S_IDLE) && !wait_q && eng_idle;
   assign is_wr    = (st_q == S_REQ) || (st_q == S_WR_CLR1) || (st_q == S_WR_CLR2);
   assign go_addr  = (st_q == S_REQ) ? req_addr_q : stat_addr_q;
   assign go_wdata = (st_q == S_REQ) ? cmd_word : hold_q;

   recal_axil_port #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_i       (go),
      .is_wr_i    (is_wr),
      .addr_i     (go_addr),
      .wdata_i    (go_wdata),
      .idle_o     (eng_idle),
      .fin_o      (fin),
      .err_o      (eng_err),
      .rdata_o    (rd),
      .m_awvalid_o(m_awvalid_o),
      .m_awready_i(m_awready_i),
      .m_awaddr_o (m_awaddr_o),
      .m_wvalid_o (m_wvalid_o),
      .m_wready_i (m_wready_i),
      .m_wdata_o  (m_wdata_o),
      .m_wstrb_o  (m_wstrb_o),
      .m_bvalid_i (m_bvalid_i),
      .m_bready_o (m_bready_o),
      .m_bresp_i  (m_bresp_i),
      .m_arvalid_o(m_arvalid_o),
      .m_arready_i(m_arready_i),
      .m_araddr_o (m_araddr_o),
      .m_rvalid_i (m_rvalid_i),
      .m_rready_o (m_rready_o),
      .m_rdata_i  (m_rdata_i),
      .m_rresp_i  (m_rresp_i)
   );

   assign rd_rdy  = rd[BIT_RDY];
   assign rd_fail = rd[BIT_FAIL];
   assign rd_busy = rd[BIT_BUSY];

   assign tmr_clr    = (st_q == S_WR_CLR1) && fin;
   assign tmr_run    = (st_q == S_POLL_CAL);
   assign tmr_sample = (st_q == S_POLL_CAL) && fin && !eng_err;
   assign tmr_busy   = rd_busy && !rd_rdy && !rd_fail;

   recal_busy_timer #(
      .LIMIT(TIMEOUT_CYCLES)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (tmr_clr),
      .run_i    (tmr_run),
      .sample_i (tmr_sample),
      .busy_i   (tmr_busy),
      .expired_o(tmr_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= S_IDLE;
         wait_q      <= 1'b0;
         chan_q      <= 1'b0;
         req_addr_q  <= '0;
         stat_addr_q <= '0;
         hold_q      <= '0;
         v_pass_q    <= 1'b0;
         v_fail_q    <= 1'b0;
         v_tout_q    <= 1'b0;
         done_q      <= 1'b0;
         pass_q      <= 1'b0;
         fail_q      <= 1'b0;
         tout_q      <= 1'b0;
         err_q       <= 1'b0;
      end else if (st_q == S_IDLE) begin
         if (accept) begin
            st_q        <= S_REQ;
            wait_q      <= 1'b0;
            chan_q      <= chan_sel_i;
            req_addr_q  <= req_addr_i;
            stat_addr_q <= stat_addr_i;
            v_pass_q    <= 1'b0;
            v_fail_q    <= 1'b0;
            v_tout_q    <= 1'b0;
            done_q      <= 1'b0;
            pass_q      <= 1'b0;
            fail_q      <= 1'b0;
            tout_q      <= 1'b0;
            err_q       <= 1'b0;
         end
      end else begin
         if (go) wait_q <= 1'b1;
         if (fin) begin
            wait_q <= 1'b0;
            if (eng_err) begin
               st_q   <= S_IDLE;
               done_q <= 1'b1;
               err_q  <= 1'b1;
            end else begin
               unique case (st_q)
                  S_REQ:      st_q <= S_POLL_RDY;
                  S_POLL_RDY: if (rd_rdy) st_q <= S_RD_CLR1;
                  S_RD_CLR1: begin
                     hold_q <= rd & CLR_MASK;
                     st_q   <= S_WR_CLR1;
                  end
                  S_WR_CLR1:  st_q <= S_POLL_CAL;
                  S_POLL_CAL: begin
                     if (rd_fail) begin
                        v_fail_q <= 1'b1;
                        st_q     <= S_RD_CLR2;
                     end else if (rd_rdy) begin
                        v_pass_q <= 1'b1;
                        st_q     <= S_RD_CLR2;
                     end else if (rd_busy && tmr_exp) begin
                        v_tout_q <= 1'b1;
                        st_q     <= S_RD_CLR2;
                     end
                  end
                  S_RD_CLR2: begin
                     hold_q <= rd & CLR_MASK;
                     st_q   <= S_WR_CLR2;
                  end
                  S_WR_CLR2: begin
                     st_q   <= S_IDLE;
                     done_q <= 1'b1;
                     pass_q <= v_pass_q;
                     fail_q <= v_fail_q;
                     tout_q <= v_tout_q;
                  end
                  default: st_q <= S_IDLE;
               endcase
            end
         end
      end
   end

   assign done_o    = done_q;
   assign pass_o    = pass_q;
   assign fail_o    = fail_q;
   assign timeout_o = tout_q;
   assign error_o   = err_q;

   // R1
   req_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == S_REQ) && m_awvalid_o) |-> (m_awaddr_o == req_addr_q));

   // R2
   poll_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_arvalid_o |-> (m_araddr_o == stat_addr_q));

   // R3
   clr_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_wvalid_o && ((st_q == S_WR_CLR1) || (st_q == S_WR_CLR2))) |-> !m_wdata_o[BIT_RDY]);

   // R4
   verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pass_o && fail_o));

   // R5
   tmo_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> (!pass_o && !fail_o && done_o));

   // R7
   err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      error_o |-> (done_o && !pass_o && !fail_o && !timeout_o));

   // R7
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (error_o && !start_i) |=> (!m_awvalid_o && !m_arvalid_o && !m_wvalid_o));

   // R8
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q != S_IDLE) && start_i) |=> ($stable(chan_q) && $stable(req_addr_q)));

endmodule

// File: tb/recal_mbox_seq_bench.sv
module recal_mbox_seq_bench;

   localparam int          TMO    = 64;
   localparam logic [31:0] A_REQ  = 32'h0500_043C;
   localparam logic [31:0] A_STAT = 32'h0500_045C;
   localparam logic [31:0] JUNK   = 32'hC3A5_5A30;
   localparam logic [31:0] W_CH0  = 32'h2005_000A;
   localparam logic [31:0] W_CH1  = 32'h6005_000A;

   typedef struct packed {
      logic        ch;
      logic [15:0] l1;
      logic [15:0] l2;
      logic [2:0]  fin;
      logic        ep;
      logic        ef;
      logic        et;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 16'd1, 16'd2,    3'b001, 1'b1, 1'b0, 1'b0},
      '{1'b1, 16'd3, 16'd0,    3'b010, 1'b0, 1'b1, 1'b0},
      '{1'b0, 16'd0, 16'd4,    3'b011, 1'b0, 1'b1, 1'b0},
      '{1'b1, 16'd2, 16'd1000, 3'b000, 1'b0, 1'b0, 1'b1},
      '{1'b0, 16'd5, 16'd1,    3'b101, 1'b1, 1'b0, 1'b0},
      '{1'b1, 16'd0, 16'd3,    3'b111, 1'b0, 1'b1, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        chan = 1'b0;
   logic        done, pass, fail, tout, err;
   logic        awvalid, wvalid, bready, arvalid, rready;
   logic        awready = 1'b0, wready = 1'b0, bvalid = 1'b0, arready = 1'b0, rvalid = 1'b0;
   logic [31:0] awaddr, araddr, wdata;
   logic [3:0]  wstrb;
   logic [1:0]  bresp = 2'b00, rresp = 2'b00;
   logic [31:0] rdata = '0;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   int          wr_cnt, p1_reads, p2_reads, mp, err_idx, rdy_delay, r6_bad;
   logic [31:0] wr_addr [8];
   logic [31:0] wr_dat  [8];
   logic [3:0]  wr_stb  [8];
   logic [15:0] m_l1, m_l2;
   logic [2:0]  m_fin;

   always #10 clk = ~clk;

   recal_mbox_seq #(
      .ADDR_W        (32),
      .TIMEOUT_CYCLES(TMO)
   ) u_recal_mbox_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .chan_sel_i (chan),
      .req_addr_i (A_REQ),
      .stat_addr_i(A_STAT),
      .done_o     (done),
      .pass_o     (pass),
      .fail_o     (fail),
      .timeout_o  (tout),
      .error_o    (err),
      .m_awvalid_o(awvalid),
      .m_awready_i(awready),
      .m_awaddr_o (awaddr),
      .m_wvalid_o (wvalid),
      .m_wready_i (wready),
      .m_wdata_o  (wdata),
      .m_wstrb_o  (wstrb),
      .m_bvalid_i (bvalid),
      .m_bready_o (bready),
      .m_bresp_i  (bresp),
      .m_arvalid_o(arvalid),
      .m_arready_i(arready),
      .m_araddr_o (araddr),
      .m_rvalid_i (rvalid),
      .m_rready_o (rready),
      .m_rdata_i  (rdata),
      .m_rresp_i  (rresp)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_reset(input logic [15:0] l1, input logic [15:0] l2,
                              input logic [2:0] fin, input int eidx, input int dly);
      wr_cnt = 0; p1_reads = 0; p2_reads = 0; mp = 0; r6_bad = 0;
      m_l1 = l1; m_l2 = l2; m_fin = fin; err_idx = eidx; rdy_delay = dly;
      for (int i = 0; i < 8; i++) begin
         wr_addr[i] = '0; wr_dat[i] = '0; wr_stb[i] = '0;
      end
   endtask

   // mailbox slave model
   initial begin
      forever begin
         @(negedge clk);
         if (awvalid && wvalid) begin
            for (int d = 0; d < rdy_delay; d++) begin
               @(negedge clk);
               if (!(awvalid && wvalid)) r6_bad++;
            end
            if (wr_cnt < 8) begin
               wr_addr[wr_cnt] = awaddr; wr_dat[wr_cnt] = wdata; wr_stb[wr_cnt] = wstrb;
            end
            awready = 1'b1; wready = 1'b1;
            @(negedge clk);
            awready = 1'b0; wready = 1'b0;
            if (wr_cnt == err_idx) bresp = 2'b10;
            else begin
               bresp = 2'b00;
               if (awaddr == A_REQ) mp = 1;
               else if (awaddr == A_STAT) mp = mp + 1;
            end
            wr_cnt++;
            bvalid = 1'b1;
            while (!bready) @(negedge clk);
            @(negedge clk);
            bvalid = 1'b0; bresp = 2'b00;
         end else if (arvalid) begin
            for (int d = 0; d < rdy_delay; d++) begin
               @(negedge clk);
               if (!arvalid) r6_bad++;
            end
            if (mp == 1) begin
               rdata = (p1_reads >= int'(m_l1)) ? (JUNK | 32'd1) : JUNK;
               p1_reads++;
            end else if (mp == 2) begin
               rdata = (p2_reads >= int'(m_l2)) ? (JUNK | {29'd0, m_fin}) : (JUNK | 32'd4);
               p2_reads++;
            end else rdata = JUNK;
            arready = 1'b1;
            @(negedge clk);
            arready = 1'b0;
            rvalid = 1'b1; rresp = 2'b00;
            while (!rready) @(negedge clk);
            @(negedge clk);
            rvalid = 1'b0;
         end
      end
   end

   task automatic kick(input logic ch);
      @(negedge clk);
      start = 1'b1; chan = ch;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(input string req);
      int n;
      n = 0;
      while (!done && n < 20000) begin
         @(negedge clk);
         n++;
      end
      if (!done) chk(req, 32'd0, 32'd1);
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      model_reset(16'd0, 16'd0, 3'b001, -1, 0);
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 done", {31'd0, done}, 32'd0);
      chk("R9 flags", {27'd0, pass, fail, tout, err, 1'b0}, 32'd0);
      chk("R9 valids", {29'd0, awvalid, wvalid, arvalid}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // vector table walk
      for (int v = 0; v < NV; v++) begin
         logic [31:0] fin_word;
         model_reset(VECS[v].l1, VECS[v].l2, VECS[v].fin, -1, v % 2 * 2);
         kick(VECS[v].ch);
         // R8 accepted start drops done
         chk("R8 done low after start", {31'd0, done}, 32'd0);
         wait_done("R2 sequence completes");
         @(negedge clk);
         fin_word = VECS[v].et ? (JUNK | 32'd4) : (JUNK | {29'd0, VECS[v].fin});
         // R1 command write
         chk("R1 cmd addr", wr_addr[0], A_REQ);
         chk("R1 cmd word", wr_dat[0], VECS[v].ch ? W_CH1 : W_CH0);
         chk("R1 strobes", {28'd0, wr_stb[0]}, 32'hF);
         // R2 ready polling count
         chk("R2 ready-phase reads", p1_reads, 32'(VECS[v].l1) + 2);
         // R3 both clears
         chk("R3 clr1 addr", wr_addr[1], A_STAT);
         chk("R3 clr1 data", wr_dat[1], JUNK);
         chk("R3 clr2 addr", wr_addr[2], A_STAT);
         chk("R3 clr2 data", wr_dat[2], fin_word & 32'hFFFF_FFFE);
         chk("R3 write count", wr_cnt, 32'd3);
         // R4 verdict, R5 timeout
         chk("R4 pass", {31'd0, pass}, {31'd0, VECS[v].ep});
         chk("R4 fail", {31'd0, fail}, {31'd0, VECS[v].ef});
         chk("R5 timeout", {31'd0, tout}, {31'd0, VECS[v].et});
         if (!VECS[v].et) chk("R4 verdict-phase reads", p2_reads, 32'(VECS[v].l2) + 2);
         chk("R7 no error", {31'd0, err}, 32'd0);
         // R6 valids held through ready delay
         chk("R6 valid hold", r6_bad, 32'd0);
      end

      // R7 write error on command
      model_reset(16'd1, 16'd1, 3'b001, 0, 0);
      kick(1'b0);
      wait_done("R7 error completes");
      repeat (20) @(negedge clk);
      chk("R7 error flag", {31'd0, err}, 32'd1);
      chk("R7 done", {31'd0, done}, 32'd1);
      chk("R7 no more writes", wr_cnt, 32'd1);
      chk("R7 no reads", p1_reads + p2_reads, 32'd0);
      chk("R7 verdicts clear", {29'd0, pass, fail, tout}, 32'd0);

      // R7 error on first clear write
      model_reset(16'd0, 16'd0, 3'b001, 1, 0);
      kick(1'b1);
      wait_done("R7 error completes");
      repeat (20) @(negedge clk);
      chk("R7 error on clear", {31'd0, err}, 32'd1);
      chk("R7 stops after clear", wr_cnt, 32'd2);
      chk("R7 no verdict reads", p2_reads, 32'd0);

      // R8 start while busy is ignored
      model_reset(16'd6, 16'd2, 3'b001, -1, 0);
      kick(1'b0);
      repeat (5) @(negedge clk);
      start = 1'b1; chan = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done("R8 sequence completes");
      repeat (20) @(negedge clk);
      chk("R8 error cleared by start", {31'd0, err}, 32'd0);
      chk("R8 single command", wr_cnt, 32'd3);
      chk("R8 original channel", wr_dat[0], W_CH0);
      chk("R8 pass", {31'd0, pass}, 32'd1);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule